// File: doc/BRIEF.md
# Portrait RGB Raster Timing Generator

This block drives the raster for a parallel-RGB LCD panel held in portrait orientation. It runs on a fast system clock and moves one pixel position per cycle in which the pixel clock enable is high. For every position it presents the following outputs, so that an upstream pixel source can fetch the matching data:

- the column and the row;
- active-low horizontal and vertical sync;
- an active-high data enable;
- a single-cycle frame-start marker.

Every timing value is a parameter. The defaults describe a 480-wide, 640-tall panel. A line has 480 visible pixels, then 24 clocks of front porch, 8 clocks of sync and 8 clocks of back porch, for 520 clocks in all. A frame has 640 visible lines, then 4 lines of front porch, 2 lines of sync and 2 lines of back porch, for 648 lines in all. With a pixel rate near 22.15 MHz the frame rate comes out at about 65.7 Hz.

A panel of this kind takes its pixel data on the clock edge opposite to the one that launches its syncs. For that reason the block also provides a copy of data enable that is re-registered on the falling clock edge. The counters advance internally one enable ahead of the outputs. All outputs are registered and change together.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst` is sampled high on a rising edge, the outputs go to these values: `hsync_n`=1, `vsync_n`=1, `de`=0, `frame_start`=0, `col`=0 and `row`=0.
- R2: Across successive enabled steps, `col` counts up by one and returns from HTOTAL-1 to 0. Here HTOTAL is H_ACTIVE+H_FRONT+H_SYNC+H_BACK, which is 520 by default.
- R3: `row` changes only on a step where `col` goes from HTOTAL-1 back to 0. On that step it counts up by one, and it returns from VTOTAL-1 to 0. VTOTAL is 648 by default.
- R4: `de` is 1 exactly when `col` < H_ACTIVE and `row` < V_ACTIVE.
- R5: `hsync_n` is 0 exactly when H_ACTIVE+H_FRONT ≤ `col` < H_ACTIVE+H_FRONT+H_SYNC, whatever the row.
- R6: `vsync_n` is 0 exactly when V_ACTIVE+V_FRONT ≤ `row` < V_ACTIVE+V_FRONT+V_SYNC. In those rows it stays 0 for every column.
- R7: `frame_start` is high for exactly one clock cycle, the cycle in which the outputs have just moved to column 0, row 0. At all other times it is 0.
- R8: In a cycle where `pix_ce` is low, `col`, `row`, `de`, `hsync_n` and `vsync_n` all hold their values.
- R9: `de_late` is updated on each falling clock edge. It is 0 if `rst` is high at that edge and otherwise takes the current `de`. So, seen just after a rising edge, it shows the `de` value from the previous cycle.
- R10: The first enabled step after reset presents column 0, row 0, with `de`=1 and `frame_start`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_ce | input | 1 | Pixel clock enable; each high cycle advances one position |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable, high over visible pixels |
| de_late | output | 1 | Data enable re-registered on the falling clock edge |
| frame_start | output | 1 | One-cycle pulse at the first visible pixel of a frame |
| col | output | $clog2(HTOTAL), 10 by default | Current pixel column |
| row | output | $clog2(VTOTAL), 10 by default | Current line |

## Verification
A horizontal counter that has drifted moves the sync pulse and the data enable window inside the very next line. A vertical counter in the wrong state moves the vertical sync row and the frame-start pulse, so it appears within one frame. Because of this, the bench compares every output on every cycle against a position computed from the count of enables since reset. It uses a shrunken raster, so that many whole frames fit into a short run. The enable patterns are continuous, sparse and reset-interrupted; these catch counters that advance without an enable, outputs that hold badly, and a late copy that samples the wrong phase.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Registered control outputs of the timing generator, kept together so
  // that they always change in the same cycle.
  typedef struct packed {
    logic hsync_n;
    logic vsync_n;
    logic de;
    logic frame_start;
  } raster_sig_t;

  localparam raster_sig_t RASTER_IDLE = '{
    hsync_n:     1'b1,
    vsync_n:     1'b1,
    de:          1'b0,
    frame_start: 1'b0
  };

endpackage

// File: rtl/raster_axis_counter.sv
module raster_axis_counter #(
  parameter int TOTAL = 520,
  parameter int W     = $clog2(TOTAL)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic         last
);

  localparam logic [W-1:0] LAST_VAL = W'(TOTAL - 1);

  assign last = (cnt == LAST_VAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= last ? '0 : cnt + W'(1);
    end
  end

  // R2 / R3: the count never leaves the axis range
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST_VAL);

  // R2 / R3: a step at the last position wraps to zero
  p_cnt_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (step && last) |=> (cnt == '0));

  // R8: no step, no movement
  p_cnt_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt));

endmodule

// File: rtl/raster_axis_decode.sv
module raster_axis_decode #(
  parameter int ACTIVE = 480,
  parameter int FRONT  = 24,
  parameter int SYNC   = 8,
  parameter int W      = 10
) (
  input  logic [W-1:0] cnt,
  output logic         active,
  output logic         sync_on,
  output logic         at_zero
);

  localparam int SYNC_BEG = ACTIVE + FRONT;
  localparam int SYNC_END = ACTIVE + FRONT + SYNC;

  logic [31:0] cext;
  assign cext    = 32'(cnt);
  assign active  = (cext < 32'(ACTIVE));
  assign at_zero = (cnt == '0);

  generate
    if (SYNC > 0) begin : g_sync
      assign sync_on = (cext >= 32'(SYNC_BEG)) && (cext < 32'(SYNC_END));
    end else begin : g_nosync
      assign sync_on = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int H_ACTIVE = 480,
  parameter int H_FRONT  = 24,
  parameter int H_SYNC   = 8,
  parameter int H_BACK   = 8,
  parameter int V_ACTIVE = 640,
  parameter int V_FRONT  = 4,
  parameter int V_SYNC   = 2,
  parameter int V_BACK   = 2,
  localparam int HTOTAL  = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
  localparam int VTOTAL  = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
  localparam int HW      = $clog2(HTOTAL),
  localparam int VW      = $clog2(VTOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_ce,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          de,
  output logic          de_late,
  output logic          frame_start,
  output logic [HW-1:0] col,
  output logic [VW-1:0] row
);

  // Internal position: one enabled step ahead of the registered outputs.
  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_pos;
  logic          h_last, v_last;
  logic          h_act, h_sync, h_zero;
  logic          v_act, v_sync, v_zero;

  raster_axis_counter #(.TOTAL(HTOTAL), .W(HW)) u_hcnt (
    .clk  (clk),
    .rst  (rst),
    .step (pix_ce),
    .cnt  (h_pos),
    .last (h_last)
  );

  raster_axis_counter #(.TOTAL(VTOTAL), .W(VW)) u_vcnt (
    .clk  (clk),
    .rst  (rst),
    .step (pix_ce & h_last),
    .cnt  (v_pos),
    .last (v_last)
  );

  raster_axis_decode #(.ACTIVE(H_ACTIVE), .FRONT(H_FRONT), .SYNC(H_SYNC), .W(HW)) u_hdec (
    .cnt     (h_pos),
    .active  (h_act),
    .sync_on (h_sync),
    .at_zero (h_zero)
  );

  raster_axis_decode #(.ACTIVE(V_ACTIVE), .FRONT(V_FRONT), .SYNC(V_SYNC), .W(VW)) u_vdec (
    .cnt     (v_pos),
    .active  (v_act),
    .sync_on (v_sync),
    .at_zero (v_zero)
  );

  raster_sig_t   sig_d, sig_q;
  logic [HW-1:0] col_q;
  logic [VW-1:0] row_q;
  logic          primed;
  logic          de_late_q;

  always_comb begin
    sig_d.hsync_n     = ~h_sync;
    sig_d.vsync_n     = ~v_sync;
    sig_d.de          = h_act & v_act;
    sig_d.frame_start = h_zero & v_zero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_q  <= RASTER_IDLE;
      col_q  <= '0;
      row_q  <= '0;
      primed <= 1'b0;
    end else if (pix_ce) begin
      sig_q  <= sig_d;
      col_q  <= h_pos;
      row_q  <= v_pos;
      primed <= 1'b1;
    end else begin
      sig_q.frame_start <= 1'b0;
    end
  end

  // Late copy of data enable, launched on the opposite clock edge.
  always_ff @(negedge clk) begin
    if (rst) de_late_q <= 1'b0;
    else     de_late_q <= sig_q.de;
  end

  assign hsync_n     = sig_q.hsync_n;
  assign vsync_n     = sig_q.vsync_n;
  assign de          = sig_q.de;
  assign frame_start = sig_q.frame_start;
  assign de_late     = de_late_q;
  assign col         = col_q;
  assign row         = row_q;

  // R2: column advances by one between wraps
  p_col_step_r2: assert property (@(posedge clk) disable iff (rst)
    (pix_ce && primed && col != HW'(HTOTAL - 1)) |=> (col == $past(col) + HW'(1)));

  // R3: row is unchanged when column does not wrap
  p_row_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (pix_ce && primed && col != HW'(HTOTAL - 1)) |=> $stable(row));

  // R3: row advances on a column wrap
  p_row_step_r3: assert property (@(posedge clk) disable iff (rst)
    (pix_ce && primed && col == HW'(HTOTAL - 1) && row != VW'(VTOTAL - 1))
      |=> (row == $past(row) + VW'(1)));

  // R4: data enable only inside the visible window
  p_de_window_r4: assert property (@(posedge clk) disable iff (rst)
    de |-> ((32'(col) < 32'(H_ACTIVE)) && (32'(row) < 32'(V_ACTIVE))));

  // R6: vertical sync only in the sync rows
  p_vs_rows_r6: assert property (@(posedge clk) disable iff (rst)
    !vsync_n |-> ((32'(row) >= 32'(V_ACTIVE + V_FRONT)) &&
                  (32'(row) <  32'(V_ACTIVE + V_FRONT + V_SYNC))));

  // R7: frame start marks the origin and lasts one cycle
  p_fs_origin_r7: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (col == '0 && row == '0 && de));
  p_fs_single_r7: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

  // R8: outputs hold while the enable is low
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!pix_ce && primed) |=> ($stable(col) && $stable(row) && $stable(de) &&
                             $stable(hsync_n) && $stable(vsync_n)));

  // R9: the falling-edge copy seen at a rising edge equals de of the cycle before
  p_late_phase_r9: assert property (@(posedge clk) disable iff (rst)
    de_late == de);

endmodule

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;

  localparam int HA = 6, HF = 2, HS = 3, HB = 1;
  localparam int VA = 4, VF = 1, VS = 2, VB = 1;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int FT = HT * VT;
  localparam int HW = $clog2(HT);
  localparam int VW = $clog2(VT);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pix_ce = 1'b0;
  logic          hsync_n, vsync_n, de, de_late, frame_start;
  logic [HW-1:0] col;
  logic [VW-1:0] row;

  int checks = 0;
  int errors = 0;
  int n_steps = 0;
  logic prev_de = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  raster_timing_gen #(
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB)
  ) u_raster_timing_gen (
    .clk(clk), .rst(rst), .pix_ce(pix_ce),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de), .de_late(de_late),
    .frame_start(frame_start), .col(col), .row(row)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // One clock: apply inputs, wait for the edge, compare every output.
  task automatic step(input logic ce_v, input logic rst_v);
    int p, c, r;
    logic de_e, hs_e, vs_e, fs_e, late_e;
    string tcol, trow, tsig;
    pix_ce = ce_v;
    rst    = rst_v;
    @(posedge clk);
    #2;
    late_e = rst_v ? 1'b0 : prev_de;
    if (rst_v) n_steps = 0;
    else if (ce_v) n_steps++;
    if (n_steps == 0) begin
      c = 0; r = 0; de_e = 0; hs_e = 1; vs_e = 1; fs_e = 0;
      tcol = "R1"; trow = "R1"; tsig = "R1";
    end else begin
      p = (n_steps - 1) % FT;
      c = p % HT;
      r = p / HT;
      de_e = (c < HA) && (r < VA);
      hs_e = !((c >= HA + HF) && (c < HA + HF + HS));
      vs_e = !((r >= VA + VF) && (r < VA + VF + VS));
      fs_e = ce_v && (c == 0) && (r == 0);
      tcol = "R2"; trow = "R3"; tsig = "R4";
      if (!ce_v) begin tcol = "R8"; trow = "R8"; tsig = "R8"; end
      if (n_steps == 1 && ce_v) begin tcol = "R10"; trow = "R10"; end
    end
    check(tcol, "col", int'(col), c);
    check(trow, "row", int'(row), r);
    check(tsig, "de", int'(de), int'(de_e));
    check((n_steps == 0) ? "R1" : "R5", "hsync_n", int'(hsync_n), int'(hs_e));
    check((n_steps == 0) ? "R1" : "R6", "vsync_n", int'(vsync_n), int'(vs_e));
    check((n_steps == 0) ? "R1" : "R7", "frame_start", int'(frame_start), int'(fs_e));
    check("R9", "de_late", int'(de_late), int'(late_e));
    prev_de = de;
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    // R1: reset held, enable high must not move anything
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1);
    // R10 then R2..R7: continuous enable over three frames
    for (int i = 0; i < 3 * FT + 5; i++) step(1'b1, 1'b0);
    // R8: sparse enable pattern (one in three cycles)
    for (int i = 0; i < 2 * FT * 3; i++) step((i % 3) == 0, 1'b0);
    // Pseudo-random enable over more than two frames
    for (int i = 0; i < 5 * FT; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], 1'b0);
    end
    // R1 mid-frame reset, then R10 restart with a gap before the first enable
    for (int i = 0; i < 17; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
    for (int i = 0; i < FT + 3; i++) step(1'b1, 1'b0);
    summary();
  end

endmodule